// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block acts as the target end of a three-wire serial memory link. A host drives a select line, a serial clock and a data line into it, and reads a data line back. While select is high, the block watches the input stream for a start bit. It then collects a two-bit command code and an eight-bit word address. Depending on the command, it returns stored words, accepts a new word, or changes the write permission latch. The storage behind the link is an internal array of 256 words of 16 bits each.

The serial pins are sampled in the system clock domain through a short synchroniser, and all link activity is timed from detected rising edges of the serial clock. The link has no valid/ready handshake and no back-pressure. Each serial clock rise moves exactly one bit in each direction, so the host sets the pace entirely. The block can never stall the host, and the host must accept each output bit before its next rise. The data output is driven only while the block has something to say: read data or the busy/ready status. At all other times the output-enable is low.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, the output-enable is low, writes are disabled, and word k of the array holds {~k, k} (high byte is the inverted address, low byte is the address).
- R2: The output-enable is low in every cycle while select is low. The data output changes only in response to a serial clock rising edge, or when select is raised with a busy status pending.
- R3: While select is high and no instruction is in progress, input bits of 0 are skipped. The first 1 sampled on a rising edge is the start bit.
- R4: After the start bit, the block takes a two-bit code and then an 8-bit address, each most significant bit first. For code 10 (read), the rise that samples the last address bit puts a dummy 0 on the output. The next 16 rises put out the addressed word, most significant bit first.
- R5: If select stays high after a read word, the next word follows immediately, with no dummy bit. The address increments by one each time and wraps from 255 to 0.
- R6: Code 00 with address bits [7:6] = 11 enables writes. Code 00 with bits [7:6] = 00 disables them. The setting persists until the other of the two is received or until reset.
- R7: Code 01 (write) with writes enabled stores the 16 data bits that follow the address, most significant bit first, at that address.
- R8: A write received while writes are disabled is shifted in completely. It leaves the array unchanged and produces no busy status.
- R9: After an accepted write, when select is lowered and raised again, the output is enabled and reads 0. It keeps reading 0 for the first BUSY_CLKS-1 serial clock rises and reads 1 from the BUSY_CLKS-th rise on.
- R10: Reads return stored data whether writes are enabled or disabled.
- R11: Lowering select in the middle of an instruction abandons it. The next selection decodes a new instruction from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select, active high |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data into the block |
| dout | output | 1 | Serial data out of the block |
| dout_oe | output | 1 | High when dout is driven |

## Verification
The bench targets the read boundaries. It checks for the single dummy zero, which a miscounting design would repeat between words or leave out. It checks the 255-to-0 wrap, which a wrong incrementer would turn into a stray address. It checks that the bit order is most significant first, which reversed shifting would garble. It also covers the write permission: a write while disabled must neither alter the word nor raise a busy status, and a design that ignores the latch would corrupt memory. The busy window is counted rise by rise, so a design with an off-by-one counter reports ready one clock early or late. An instruction abandoned half-way must leave no residue, or the next command would decode from stale bits.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CMD,
    ST_RD,
    ST_WR,
    ST_DONE,
    ST_BUSY,
    ST_READY
  } mw_state_e;

  localparam logic [1:0] CODE_READ  = 2'b10;
  localparam logic [1:0] CODE_WRITE = 2'b01;
  localparam logic [1:0] CODE_EXT   = 2'b00;

  localparam logic [1:0] EXT_WR_ON  = 2'b11;
  localparam logic [1:0] EXT_WR_OFF = 2'b00;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic cs_s,
  output logic din_s,
  output logic rise
);
  localparam int W = 3;

  logic [W-1:0] chain [STAGES];
  logic         sclk_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= {cs, sclk, din};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= chain[STAGES-1][1];
  end

  assign cs_s  = chain[STAGES-1][2];
  assign din_s = chain[STAGES-1][0];
  assign rise  = chain[STAGES-1][1] & ~sclk_prev;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [ADDR_W-1:0] IA = ADDR_W'(i);
      localparam logic [DATA_W-1:0] IV = DATA_W'({~IA, IA});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   mem[i] <= IV;
        else if (we && (waddr == ADDR_W'(i)))         mem[i] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[raddr];
endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
  parameter int BUSY_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(BUSY_CLKS + 1);

  logic [CW-1:0] cnt;

  assign expire = tick && (cnt == CW'(BUSY_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (tick && !expire)  cnt <= cnt + 1'b1;
  end

  // R9: the busy count never runs past its window
  a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(BUSY_CLKS));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BUSY_CLKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic dout_oe
);
  localparam int CMD_W = 2 + ADDR_W;
  localparam int MAXW  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW);

  logic              cs_s, din_s, rise;
  mw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-2:0]  cmd_sr;
  logic [CMD_W-1:0]  full;
  logic [1:0]        code;
  logic [ADDR_W-1:0] cmd_addr, addr_q, raddr;
  logic [DATA_W-1:0] data_sr, rdata, wdata;
  logic              wen_q, pend_q, dout_q;
  logic              mem_we, busy_clr, busy_tick, busy_exp;
  logic              last_cmd_bit, last_data_bit;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
    .cs_s(cs_s), .din_s(din_s), .rise(rise)
  );

  assign full     = {cmd_sr, din_s};
  assign code     = full[CMD_W-1 -: 2];
  assign cmd_addr = full[ADDR_W-1:0];
  assign raddr    = (state == ST_RD) ? addr_q + 1'b1 : cmd_addr;
  assign wdata    = {data_sr[DATA_W-2:0], din_s};

  assign last_cmd_bit  = (cnt == CNT_W'(CMD_W - 1));
  assign last_data_bit = (cnt == CNT_W'(DATA_W - 1));

  assign mem_we = cs_s && rise && (state == ST_WR) && last_data_bit && wen_q;

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr_q), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign busy_clr  = (state != ST_BUSY);
  assign busy_tick = cs_s && rise && (state == ST_BUSY);

  mw_busy #(.BUSY_CLKS(BUSY_CLKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .clear(busy_clr), .tick(busy_tick),
    .expire(busy_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cmd_sr  <= '0;
      addr_q  <= '0;
      data_sr <= '0;
      wen_q   <= 1'b0;
      pend_q  <= 1'b0;
      dout_q  <= 1'b0;
    end else if (!cs_s) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pend_q) begin
            state  <= ST_BUSY;
            dout_q <= 1'b0;
          end else begin
            state <= ST_START;
          end
        end
        ST_START, ST_READY: begin
          if (rise && din_s) begin
            state <= ST_CMD;
            cnt   <= '0;
          end
        end
        ST_CMD: begin
          if (rise) begin
            cmd_sr <= full[CMD_W-2:0];
            cnt    <= cnt + 1'b1;
            if (last_cmd_bit) begin
              cnt <= '0;
              unique case (code)
                CODE_READ: begin
                  state   <= ST_RD;
                  addr_q  <= cmd_addr;
                  data_sr <= rdata;
                  dout_q  <= 1'b0;
                end
                CODE_WRITE: begin
                  state  <= ST_WR;
                  addr_q <= cmd_addr;
                end
                CODE_EXT: begin
                  state <= ST_DONE;
                  if (cmd_addr[ADDR_W-1 -: 2] == EXT_WR_ON)
                    wen_q <= 1'b1;
                  else if (cmd_addr[ADDR_W-1 -: 2] == EXT_WR_OFF)
                    wen_q <= 1'b0;
                end
                default: state <= ST_DONE;
              endcase
            end
          end
        end
        ST_RD: begin
          if (rise) begin
            dout_q <= data_sr[DATA_W-1];
            if (last_data_bit) begin
              addr_q  <= addr_q + 1'b1;
              data_sr <= rdata;
              cnt     <= '0;
            end else begin
              data_sr <= {data_sr[DATA_W-2:0], 1'b0};
              cnt     <= cnt + 1'b1;
            end
          end
        end
        ST_WR: begin
          if (rise) begin
            data_sr <= wdata;
            cnt     <= cnt + 1'b1;
            if (last_data_bit) begin
              state <= ST_DONE;
              cnt   <= '0;
              if (wen_q) pend_q <= 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (busy_exp) begin
            state  <= ST_READY;
            dout_q <= 1'b1;
            pend_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign dout    = dout_q;
  assign dout_oe = (state == ST_RD) || (state == ST_BUSY) || (state == ST_READY);

  // R2: deselect releases the output on the next cycle
  a_r2_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !dout_oe);

  // R2: without a serial clock rise the active output holds its value
  a_r2_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && state != ST_IDLE) |=> $stable(dout_q));

  // R4: the first bit of any read is the dummy zero
  a_r4_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_RD) |-> !dout_q);

  // R6: the write latch only moves on a decoded instruction
  a_r6_latch_on_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen_q) |-> $past(state == ST_CMD && rise));

  // R9: reporting ready means nothing is still pending
  a_r9_ready_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READY) |-> !pend_q);
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int BUSY = 4;
  localparam int NV   = 6;
  // {address, expected word}
  localparam logic [23:0] RD_VEC [NV] = '{
    {8'h00, 16'hFF00}, {8'h01, 16'hFE01}, {8'h5A, 16'hA55A},
    {8'h80, 16'h7F80}, {8'hFE, 16'h01FE}, {8'h3C, 16'hC33C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  int   n_chk = 0, n_bad = 0;
  int   cyc = 0;
  logic last_o;

  always #2 clk = ~clk;

  mw_eeprom #(.BUSY_CLKS(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk) din = b;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    last_o = dout;
    sclk = 1'b0;
  endtask

  task automatic cs_up();
    @(negedge clk) cs = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) cs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [7:0] a);
    tick(1'b1);
    tick(op[1]);
    tick(op[0]);
    for (int i = 7; i >= 0; i--) tick(a[i]);
  endtask

  task automatic read_word(output logic [15:0] w);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      tick(1'b0);
      w = {w[14:0], last_o};
    end
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] d);
    cs_up();
    send_cmd(2'b01, a);
    for (int i = 15; i >= 0; i--) tick(d[i]);
    cs_down();
  endtask

  task automatic read_at(input string tag, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] w;
    cs_up();
    send_cmd(2'b10, a);
    check({tag, " dummy"}, {15'd0, last_o}, 16'd0);
    read_word(w);
    check(tag, w, exp);
    cs_down();
  endtask

  initial begin
    logic [15:0] w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", {15'd0, dout_oe}, 16'd0);

    // vector table: reads of reset contents (R1, R4)
    for (int v = 0; v < NV; v++) begin
      cs_up();
      send_cmd(2'b10, RD_VEC[v][23:16]);
      check("R4 dummy zero", {15'd0, last_o}, 16'd0);
      check("R2 oe during read", {15'd0, dout_oe}, 16'd1);
      read_word(w);
      check("R1 R4 word", w, RD_VEC[v][15:0]);
      cs_down();
      check("R2 oe after deselect", {15'd0, dout_oe}, 16'd0);
    end

    // R5: continuous read with wrap, no dummy between words
    cs_up();
    send_cmd(2'b10, 8'hFE);
    read_word(w); check("R5 first word", w, 16'h01FE);
    read_word(w); check("R5 second word", w, 16'h00FF);
    read_word(w); check("R5 wrap to 0", w, 16'hFF00);
    cs_down();

    // R3: leading zeros skipped before the start bit
    cs_up();
    for (int i = 0; i < 5; i++) tick(1'b0);
    check("R3 oe idle", {15'd0, dout_oe}, 16'd0);
    send_cmd(2'b10, 8'h5A);
    read_word(w); check("R3 read after zeros", w, 16'hA55A);
    cs_down();

    // R11: abandoned instruction
    cs_up();
    tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b1);
    cs_down();
    read_at("R11 fresh decode", 8'h01, 16'hFE01);

    // R8: write while disabled
    write_word(8'h10, 16'h1234);
    cs_up();
    check("R8 no busy", {15'd0, dout_oe}, 16'd0);
    cs_down();
    read_at("R8 unchanged", 8'h10, 16'hEF10);

    // R6 enable, R7 write, R9 busy
    cs_up(); send_cmd(2'b00, 8'hC0); cs_down();
    write_word(8'h10, 16'hBEEF);
    cs_up();
    check("R9 busy oe", {15'd0, dout_oe}, 16'd1);
    check("R9 busy low", {15'd0, dout}, 16'd0);
    for (int i = 0; i < BUSY - 1; i++) begin
      tick(1'b0);
      check("R9 still busy", {15'd0, last_o}, 16'd0);
    end
    tick(1'b0);
    check("R9 ready", {15'd0, last_o}, 16'd1);
    cs_down();
    read_at("R7 R10 written word", 8'h10, 16'hBEEF);

    // R6 disable, then write is blocked, reads still work (R10)
    cs_up(); send_cmd(2'b00, 8'h00); cs_down();
    write_word(8'h10, 16'h0000);
    cs_up();
    check("R6 R8 no busy after disable", {15'd0, dout_oe}, 16'd0);
    cs_down();
    read_at("R6 R10 word kept", 8'h10, 16'hBEEF);

    summary();
    $finish;
  end
endmodule